// File: doc/BRIEF.md
# Received Packet Filter and Checker

This block sits between the serial-bus receive deserializer and the receive FIFO. It takes one packet at a time as a stream of 32-bit quadlets, framed by a start marker on the first quadlet and an end marker on the last. It decides from the first quadlet whether the packet concerns this node, checks the header CRC, and hands accepted quadlets to the FIFO write port. Every stored packet is closed by one status quadlet that holds the acknowledge code the node sent or would have sent.

Writes are provisional until the block pulses `fifo_commit`. A `fifo_rewind` pulse tells the FIFO to drop every provisional quadlet written since the last commit. This lets the block write header quadlets as they arrive and still keep a packet with a bad header, a truncated header, or a FIFO overflow out of view of the reader. Cycle-start packets are recognised: their cycle-time quadlet goes to a cycle-timer load port, and a configuration input chooses whether they are also stored.

The acknowledge code of every addressed packet with a good header also appears on `ack_code`, for the acknowledge sender.

Top module: `rx_pkt_filter`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `fifo_wr`, `fifo_commit`, `fifo_rewind`, `ack_valid` and `ct_load` are all low.
- R2: The transaction code is in first-quadlet bits [7:4]. For non-isochronous codes the destination ID is in bits [31:16], with the bus in [31:22] and the node in [21:16]. A packet is accepted only if the ID equals `local_id`, or if the node is 63 and the bus equals the local bus or 0x3FF. Any other packet produces no write, no rewind of its own and no acknowledge.
- R3: An isochronous packet (code 0xA) is accepted only when first-quadlet bits [13:8] equal `iso_chan`. Its header is one quadlet.
- R4: The header is 3 quadlets for codes 0x2, 0x4 and 0x5, and 4 quadlets for codes 0x0, 0x1, 0x6, 0x7 and 0x8. A header CRC quadlet follows, and it is never written. All other codes are discarded like unaddressed packets.
- R5: Both CRCs use polynomial 0x04C11DB7 and an all-ones start value. Each quadlet is fed in MSB first, and the result is inverted. The header CRC covers the header quadlets; the data CRC covers the payload quadlets.
- R6: On a header CRC mismatch, or an end marker before the header CRC, nothing of the packet is committed. A rewind is pulsed if any quadlet of it was written, the remaining quadlets cause no write, and no acknowledge is given.
- R7: For codes 0x1, 0x7 and 0xA, the quadlets between the header CRC and the final quadlet are written in order. The final quadlet is the data CRC and is not written.
- R8: After the last stored quadlet, one status quadlet is written: the acknowledge code in bits [3:0] and zeros above. It comes with `fifo_commit` and with `ack_valid`/`ack_code` in the same cycle.
- R9: The codes are as follows. Pending (0x2) applies to codes 0x0 and 0x1 with good data. Data error (0xD) applies to a payload packet whose data CRC mismatches or is missing (end marker on the header CRC). Complete (0x1) applies to everything else that is accepted.
- R10: A cycle-start packet (code 0x8) with a good header pulses `ct_load` with header quadlet 3, one cycle after the header CRC beat. It is stored only when `keep_cycstart` is 1, but is acknowledged as complete either way.
- R11: If `fifo_full` is high on a beat that needs a write, the packet's provisional quadlets are rewound and the rest of the packet is ignored. At its end marker, `ack_code` reports busy (0x4) and nothing is committed.
- R12: Each stored quadlet is written one cycle after its beat is taken. The status quadlet is written one cycle after the end-marker beat.
- R13: A start marker that arrives in the middle of a packet abandons the old packet: its provisional quadlets are rewound, and the new packet is processed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| local_id | input | 16 | This node's bus and node number |
| iso_chan | input | 6 | Isochronous channel to accept |
| keep_cycstart | input | 1 | Store cycle-start packets in the FIFO |
| in_valid | input | 1 | A quadlet is present this cycle |
| in_sop | input | 1 | First quadlet of a packet |
| in_eop | input | 1 | Last quadlet of a packet |
| in_quad | input | 32 | Received quadlet |
| fifo_full | input | 1 | FIFO cannot take a write issued next cycle |
| fifo_wr | output | 1 | Provisional write strobe |
| fifo_wdata | output | 32 | Write data |
| fifo_commit | output | 1 | Make everything written since the last commit visible |
| fifo_rewind | output | 1 | Drop provisional quadlets (applies before a same-cycle write) |
| ack_valid | output | 1 | Acknowledge code valid |
| ack_code | output | 4 | Acknowledge code of the finished packet |
| ct_load | output | 1 | Cycle-time update strobe |
| ct_value | output | 32 | Cycle-time quadlet from a cycle-start packet |

## Verification
The assertions assume that beats arrive framed: a start marker begins every packet, and the end marker is set on exactly one beat of it. They also assume that `fifo_full` is meaningful only on beats where `in_valid` is high. The stimulus builds each packet from a start beat to an end beat and raises `fifo_full` only on a chosen beat, lowering it again on the next. The only deliberately broken framing is the mid-packet restart, and that is the case the block is required to handle.

// File: rtl/rxpf_pkg.sv
package rxpf_pkg;
    localparam int QW      = 32;
    localparam int ID_W    = 16;
    localparam int NODE_W  = 6;
    localparam int BUS_W   = ID_W - NODE_W;
    localparam int TC_W    = 4;
    localparam int CODE_W  = 4;
    localparam int CNT_W   = 3;
    localparam logic [QW-1:0] CRC_POLY = 32'h04C11DB7;

    typedef enum logic [CODE_W-1:0] {
        ACK_COMPLETE = 4'h1,
        ACK_PENDING  = 4'h2,
        ACK_BUSY     = 4'h4,
        ACK_DATA_ERR = 4'hD
    } ack_e;

    typedef enum logic [2:0] {
        S_IDLE, S_HDR, S_BODY, S_TAIL, S_DROP, S_BUSY
    } state_e;

    typedef struct packed {
        logic             payload;
        logic             is_cyc;
        logic             wr_req;
        logic [CNT_W-1:0] hlen;
    } kind_t;

    typedef struct packed {
        logic              wr;
        logic [QW-1:0]     data;
        logic              commit;
        logic              rewind;
        logic              ack;
        logic [CODE_W-1:0] code;
        logic              ct;
        logic [QW-1:0]     ctv;
    } out_t;

    function automatic logic tc_known(logic [TC_W-1:0] tc);
        return tc inside {4'h0, 4'h1, 4'h2, 4'h4, 4'h5, 4'h6, 4'h7, 4'h8, 4'hA};
    endfunction

    function automatic logic tc_iso(logic [TC_W-1:0] tc);
        return tc == 4'hA;
    endfunction

    function automatic kind_t decode_kind(logic [TC_W-1:0] tc);
        kind_t k;
        k = '0;
        case (tc)
            4'h0:             begin k.wr_req = 1'b1; k.hlen = 3'd4; end
            4'h1:             begin k.wr_req = 1'b1; k.payload = 1'b1; k.hlen = 3'd4; end
            4'h2, 4'h4, 4'h5: k.hlen = 3'd3;
            4'h6:             k.hlen = 3'd4;
            4'h7:             begin k.payload = 1'b1; k.hlen = 3'd4; end
            4'h8:             begin k.is_cyc = 1'b1; k.hlen = 3'd4; end
            4'hA:             begin k.payload = 1'b1; k.hlen = 3'd1; end
            default:          k.hlen = 3'd4;
        endcase
        return k;
    endfunction
endpackage

// File: rtl/rxpf_crc_acc.sv
module rxpf_crc_acc #(
    parameter int              W    = 32,
    parameter logic [W-1:0]    POLY = 32'h04C11DB7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         upd,
    input  logic [W-1:0] din,
    output logic [W-1:0] result
);
    localparam logic [W-1:0] SEED = '1;

    logic [W-1:0] acc_q;
    logic [W-1:0] base;

    function automatic logic [W-1:0] step(logic [W-1:0] c, logic [W-1:0] d);
        logic [W-1:0] r;
        logic         fb;
        r = c;
        for (int i = W - 1; i >= 0; i--) begin
            fb = r[W-1] ^ d[i];
            r  = {r[W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
        return r;
    endfunction

    assign base   = clr ? SEED : acc_q;
    assign result = ~acc_q;

    always_ff @(posedge clk) begin
        if (rst)      acc_q <= SEED;
        else if (upd) acc_q <= step(base, din);
        else if (clr) acc_q <= SEED;
    end
endmodule

// File: rtl/rxpf_dest_match.sv
module rxpf_dest_match import rxpf_pkg::*; (
    input  logic [ID_W-1:0]   local_id,
    input  logic [NODE_W-1:0] iso_chan,
    input  logic [ID_W-1:0]   dest,
    input  logic [NODE_W-1:0] chan,
    input  logic [TC_W-1:0]   tc,
    output logic              hit,
    output kind_t             kind
);
    localparam logic [NODE_W-1:0] ALL_NODES = '1;
    localparam logic [BUS_W-1:0]  THIS_BUS  = '1;

    logic [BUS_W-1:0]  d_bus;
    logic [NODE_W-1:0] d_node;
    logic              own_bus;
    logic              unicast_hit;
    logic              bcast_hit;

    assign d_bus       = dest[ID_W-1:NODE_W];
    assign d_node      = dest[NODE_W-1:0];
    assign own_bus     = (d_bus == local_id[ID_W-1:NODE_W]) || (d_bus == THIS_BUS);
    assign unicast_hit = (dest == local_id);
    assign bcast_hit   = (d_node == ALL_NODES) && own_bus;
    assign kind        = decode_kind(tc);

    always_comb begin
        if (tc_iso(tc))         hit = (chan == iso_chan);
        else if (tc_known(tc))  hit = unicast_hit || bcast_hit;
        else                    hit = 1'b0;
    end
endmodule

// File: rtl/rxpf_out_stage.sv
module rxpf_out_stage import rxpf_pkg::*; (
    input  logic clk,
    input  logic rst,
    input  out_t nxt,
    output out_t cur
);
    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end
endmodule

// File: rtl/rx_pkt_filter.sv
module rx_pkt_filter import rxpf_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic [ID_W-1:0]   local_id,
    input  logic [NODE_W-1:0] iso_chan,
    input  logic              keep_cycstart,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [QW-1:0]     in_quad,
    input  logic              fifo_full,
    output logic              fifo_wr,
    output logic [QW-1:0]     fifo_wdata,
    output logic              fifo_commit,
    output logic              fifo_rewind,
    output logic              ack_valid,
    output logic [CODE_W-1:0] ack_code,
    output logic              ct_load,
    output logic [QW-1:0]     ct_value
);
    localparam logic [CNT_W-1:0] CYC_IDX = 3'd3;
    localparam int DEST_LSB = QW - ID_W;
    localparam int CHAN_LSB = 8;
    localparam int TC_LSB   = 4;

    state_e            st_q, st_d;
    kind_t             kind_q, kind_d, hit_kind;
    logic [CNT_W-1:0]  idx_q, idx_d;
    logic              store_q, store_d;
    logic              wrote_q, wrote_d;
    logic [QW-1:0]     cyc_q, cyc_d;
    logic              hit;
    logic              crc_clr, crc_upd;
    logic [QW-1:0]     crc_res;
    out_t              nxt, cur;

    rxpf_dest_match u_match (
        .local_id (local_id),
        .iso_chan (iso_chan),
        .dest     (in_quad[QW-1:DEST_LSB]),
        .chan     (in_quad[CHAN_LSB+NODE_W-1:CHAN_LSB]),
        .tc       (in_quad[TC_LSB+TC_W-1:TC_LSB]),
        .hit      (hit),
        .kind     (hit_kind)
    );

    rxpf_crc_acc #(.W(QW), .POLY(CRC_POLY)) u_crc (
        .clk    (clk),
        .rst    (rst),
        .clr    (crc_clr),
        .upd    (crc_upd),
        .din    (in_quad),
        .result (crc_res)
    );

    rxpf_out_stage u_out (
        .clk (clk),
        .rst (rst),
        .nxt (nxt),
        .cur (cur)
    );

    always_comb begin
        logic              want_wr;
        logic              is_stat;
        logic              do_fin;
        logic [CODE_W-1:0] fin_code;
        logic [CODE_W-1:0] ok_code;
        logic [QW-1:0]     wdata;

        nxt      = '0;
        st_d     = st_q;
        kind_d   = kind_q;
        idx_d    = idx_q;
        store_d  = store_q;
        wrote_d  = wrote_q;
        cyc_d    = cyc_q;
        crc_clr  = 1'b0;
        crc_upd  = 1'b0;
        want_wr  = 1'b0;
        is_stat  = 1'b0;
        do_fin   = 1'b0;
        fin_code = ACK_COMPLETE;
        ok_code  = kind_q.wr_req ? ACK_PENDING : ACK_COMPLETE;
        wdata    = in_quad;

        if (in_valid) begin
            if (in_sop) begin
                if (st_q != S_IDLE && wrote_q) nxt.rewind = 1'b1;
                wrote_d = 1'b0;
                kind_d  = hit_kind;
                idx_d   = 3'd1;
                store_d = !(hit_kind.is_cyc && !keep_cycstart);
                if (!hit) begin
                    st_d = in_eop ? S_IDLE : S_DROP;
                end else if (in_eop) begin
                    st_d = S_IDLE;
                end else begin
                    st_d    = S_HDR;
                    crc_clr = 1'b1;
                    crc_upd = 1'b1;
                    want_wr = store_d;
                end
            end else begin
                unique case (st_q)
                    S_HDR: begin
                        if (idx_q == kind_q.hlen) begin
                            if (crc_res != in_quad) begin
                                nxt.rewind = wrote_q;
                                st_d       = in_eop ? S_IDLE : S_DROP;
                            end else begin
                                nxt.ct  = kind_q.is_cyc;
                                nxt.ctv = kind_q.is_cyc ? cyc_q : '0;
                                crc_clr = 1'b1;
                                if (in_eop) begin
                                    do_fin   = 1'b1;
                                    fin_code = kind_q.payload ? ACK_DATA_ERR : ok_code;
                                end else begin
                                    st_d = kind_q.payload ? S_BODY : S_TAIL;
                                end
                            end
                        end else if (in_eop) begin
                            nxt.rewind = wrote_q;
                            st_d       = S_IDLE;
                        end else begin
                            crc_upd = 1'b1;
                            idx_d   = idx_q + 3'd1;
                            want_wr = store_q;
                            if (idx_q == CYC_IDX) cyc_d = in_quad;
                        end
                    end
                    S_BODY: begin
                        if (in_eop) begin
                            do_fin   = 1'b1;
                            fin_code = (crc_res == in_quad) ? ok_code : ACK_DATA_ERR;
                        end else begin
                            crc_upd = 1'b1;
                            want_wr = store_q;
                        end
                    end
                    S_TAIL: begin
                        if (in_eop) do_fin = 1'b1;
                        fin_code = ok_code;
                    end
                    S_DROP: begin
                        if (in_eop) st_d = S_IDLE;
                    end
                    S_BUSY: begin
                        if (in_eop) begin
                            nxt.ack  = 1'b1;
                            nxt.code = ACK_BUSY;
                            st_d     = S_IDLE;
                        end
                    end
                    default: ;
                endcase
            end

            if (do_fin) begin
                st_d     = S_IDLE;
                nxt.ack  = 1'b1;
                nxt.code = fin_code;
                if (store_q) begin
                    want_wr = 1'b1;
                    is_stat = 1'b1;
                    wdata   = {{(QW-CODE_W){1'b0}}, fin_code};
                end
            end

            if (want_wr) begin
                if (fifo_full) begin
                    if (!in_sop && wrote_q) nxt.rewind = 1'b1;
                    if (is_stat) begin
                        nxt.ack  = 1'b1;
                        nxt.code = ACK_BUSY;
                        st_d     = S_IDLE;
                    end else begin
                        st_d = S_BUSY;
                    end
                end else begin
                    nxt.wr     = 1'b1;
                    nxt.data   = wdata;
                    nxt.commit = is_stat;
                    wrote_d    = 1'b1;
                end
            end
        end

        if (st_d inside {S_IDLE, S_DROP, S_BUSY}) wrote_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= S_IDLE;
            kind_q  <= '0;
            idx_q   <= '0;
            store_q <= 1'b0;
            wrote_q <= 1'b0;
            cyc_q   <= '0;
        end else begin
            st_q    <= st_d;
            kind_q  <= kind_d;
            idx_q   <= idx_d;
            store_q <= store_d;
            wrote_q <= wrote_d;
            cyc_q   <= cyc_d;
        end
    end

    assign fifo_wr     = cur.wr;
    assign fifo_wdata  = cur.data;
    assign fifo_commit = cur.commit;
    assign fifo_rewind = cur.rewind;
    assign ack_valid   = cur.ack;
    assign ack_code    = cur.code;
    assign ct_load     = cur.ct;
    assign ct_value    = cur.ctv;

    // R8: a commit is always the status write, matching the reported code
    p_commit_status_r8: assert property (@(posedge clk) disable iff (rst)
        fifo_commit |-> (fifo_wr && ack_valid &&
                         fifo_wdata == {{(QW-CODE_W){1'b0}}, ack_code}));

    // R6: once a packet is being discarded, its further beats write nothing
    p_drop_silent_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_DROP && !(in_valid && in_sop)) |=> !fifo_wr);

    // R9: only the four defined codes leave the block
    p_ack_legal_r9: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> (ack_code inside {ACK_COMPLETE, ACK_PENDING, ACK_BUSY, ACK_DATA_ERR}));

    // R10: a cycle-time load is a single-cycle strobe
    p_ct_single_r10: assert property (@(posedge clk) disable iff (rst)
        ct_load |=> !ct_load);

    // R11: an overflowed packet is never committed
    p_busy_no_commit_r11: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_BUSY) |=> !fifo_commit);

    // R11: rewind and commit never coincide
    p_rewind_excl_r11: assert property (@(posedge clk) disable iff (rst)
        fifo_rewind |-> !fifo_commit);
endmodule

// File: tb/rx_pkt_filter_bench.sv
module rx_pkt_filter_bench;
    localparam logic [15:0] MY_ID  = 16'h0485;
    localparam logic [9:0]  MY_BUS = 10'h012;
    localparam logic [5:0]  ISO_CH = 6'd9;

    typedef struct packed {
        logic [3:0] tc;
        logic [1:0] dm;
        logic [2:0] np;
        logic       bh;
        logic       bd;
        logic       keep;
        logic [3:0] ack;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{4'h0, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 4'h2},
        '{4'h4, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 4'h1},
        '{4'h1, 2'd0, 3'd3, 1'b0, 1'b0, 1'b0, 4'h2},
        '{4'h7, 2'd0, 3'd2, 1'b0, 1'b1, 1'b0, 4'hD},
        '{4'h1, 2'd1, 3'd2, 1'b0, 1'b0, 1'b0, 4'h0},
        '{4'h5, 2'd2, 3'd0, 1'b0, 1'b0, 1'b0, 4'h1},
        '{4'h0, 2'd3, 3'd0, 1'b0, 1'b0, 1'b0, 4'h2},
        '{4'hA, 2'd0, 3'd2, 1'b0, 1'b0, 1'b0, 4'h1},
        '{4'hA, 2'd1, 3'd2, 1'b0, 1'b0, 1'b0, 4'h0},
        '{4'h6, 2'd0, 3'd0, 1'b1, 1'b0, 1'b0, 4'h0},
        '{4'h8, 2'd3, 3'd0, 1'b0, 1'b0, 1'b1, 4'h1},
        '{4'h8, 2'd3, 3'd0, 1'b0, 1'b0, 1'b0, 4'h1},
        '{4'h2, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 4'h1},
        '{4'h1, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 4'h2},
        '{4'h3, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 4'h0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        keep_cycstart = 1'b0;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [31:0] in_quad = '0;
    logic        fifo_full = 1'b0;
    logic        fifo_wr, fifo_commit, fifo_rewind, ack_valid, ct_load;
    logic [31:0] fifo_wdata, ct_value;
    logic [3:0]  ack_code;

    int n_chk = 0, n_bad = 0, n_rew = 0;
    logic [31:0] tent[$], comm[$], cts[$];
    logic [3:0]  acks[$];
    logic [31:0] pk[16], ex[16];
    int plen, exn, hl;
    bit done = 0;

    always #10 clk = ~clk;

    rx_pkt_filter u_rx_pkt_filter (
        .clk(clk), .rst(rst), .local_id(MY_ID), .iso_chan(ISO_CH),
        .keep_cycstart(keep_cycstart), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_quad(in_quad), .fifo_full(fifo_full),
        .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .fifo_commit(fifo_commit),
        .fifo_rewind(fifo_rewind), .ack_valid(ack_valid), .ack_code(ack_code),
        .ct_load(ct_load), .ct_value(ct_value)
    );

    // FIFO model: rewind first, then write, then commit
    always @(negedge clk) begin
        if (!rst) begin
            if (fifo_rewind) begin tent.delete(); n_rew++; end
            if (fifo_wr) tent.push_back(fifo_wdata);
            if (fifo_commit) begin
                foreach (tent[i]) comm.push_back(tent[i]);
                tent.delete();
            end
            if (ack_valid) acks.push_back(ack_code);
            if (ct_load) cts.push_back(ct_value);
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic logic [31:0] crc_of(int s, int n);
        logic [31:0] c;
        c = '1;
        for (int k = s; k < s + n; k++)
            for (int b = 31; b >= 0; b--) begin
                logic fb;
                fb = c[31] ^ pk[k][b];
                c  = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
            end
        return ~c;
    endfunction

    function automatic int hlen_of(logic [3:0] tc);
        case (tc)
            4'h2, 4'h4, 4'h5: return 3;
            4'hA:             return 1;
            default:          return 4;
        endcase
    endfunction

    task automatic build(input vec_t v, input int seed);
        logic [15:0] dest;
        bit pay, stored;
        hl  = hlen_of(v.tc);
        pay = (v.tc == 4'h1 || v.tc == 4'h7 || v.tc == 4'hA);
        case (v.dm)
            2'd0: dest = MY_ID;
            2'd1: dest = {MY_BUS, 6'd7};
            2'd2: dest = {MY_BUS, 6'h3F};
            default: dest = {10'h3FF, 6'h3F};
        endcase
        if (v.tc == 4'hA)
            pk[0] = {16'(v.np * 4), 2'b01, (v.dm == 0) ? ISO_CH : ISO_CH + 6'd1, 4'hA, 4'h0};
        else
            pk[0] = {dest, 6'(seed), 2'b01, v.tc, 4'h0};
        for (int k = 1; k < hl; k++) pk[k] = 32'hC0DE0000 + seed * 256 + k;
        if (pay && v.tc != 4'hA) pk[3] = {16'(v.np * 4), 16'h0};
        pk[hl] = crc_of(0, hl) ^ {31'b0, v.bh};
        plen = hl + 1;
        if (pay) begin
            for (int k = 0; k < int'(v.np); k++) pk[plen + k] = 32'h5A000000 + seed * 16 + k;
            pk[plen + v.np] = crc_of(plen, v.np) ^ {31'b0, v.bd};
            plen = plen + v.np + 1;
        end
        exn = 0;
        stored = (v.ack != 0) && !(v.tc == 4'h8 && !v.keep);
        if (stored) begin
            for (int k = 0; k < hl; k++) begin ex[exn] = pk[k]; exn++; end
            if (pay) for (int k = 0; k < int'(v.np); k++) begin ex[exn] = pk[hl + 1 + k]; exn++; end
            ex[exn] = {28'h0, v.ack}; exn++;
        end
    endtask

    task automatic send(input int n, input bit with_eop, input int full_at);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1; in_sop = (k == 0); in_eop = with_eop && (k == n - 1);
            in_quad = pk[k]; fifo_full = (k == full_at);
        end
        @(negedge clk);
        in_valid = 0; in_sop = 0; in_eop = 0; fifo_full = 0;
    endtask

    task automatic clear_obs();
        comm.delete(); acks.delete(); cts.delete(); tent.delete();
    endtask

    task automatic cmp_store(input string tag);
        chk(comm.size() == exn, tag, comm.size(), exn);
        if (comm.size() == exn)
            for (int k = 0; k < exn; k++) chk(comm[k] == ex[k], tag, comm[k], ex[k]);
    endtask

    task automatic cmp_ack(input string tag, input logic [3:0] e);
        if (e == 0) chk(acks.size() == 0, tag, acks.size(), 0);
        else begin
            chk(acks.size() == 1, tag, acks.size(), 1);
            if (acks.size() == 1) chk(acks[0] == e, tag, acks[0], e);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    initial begin
        int r0;
        string tag;
        repeat (3) @(negedge clk);
        // R1: strobes quiet in reset and just after
        chk({fifo_wr, fifo_commit, fifo_rewind, ack_valid, ct_load} == 0, "R1 in reset",
            {fifo_wr, fifo_commit, fifo_rewind, ack_valid, ct_load}, 0);
        rst = 0;
        @(negedge clk);
        chk({fifo_wr, fifo_commit, fifo_rewind, ack_valid, ct_load} == 0, "R1 after reset",
            {fifo_wr, fifo_commit, fifo_rewind, ack_valid, ct_load}, 0);

        // table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VEC[i];
            if (v.tc == 4'h8) tag = "R10";
            else if (v.tc == 4'hA) tag = "R3";
            else if (v.bh) tag = "R6";
            else if (v.bd) tag = "R9";
            else if (v.ack == 0) tag = "R2/R4";
            else tag = "R2/R9";
            clear_obs();
            r0 = n_rew;
            keep_cycstart = v.keep;
            build(v, i + 1);
            send(plen, 1, -1);
            repeat (2) @(negedge clk);
            cmp_ack($sformatf("%s ack vec%0d", tag, i), v.ack);
            cmp_store($sformatf("R4/R5/R7/R8 store vec%0d", i));
            chk(tent.size() == 0, "R6 no leftover", tent.size(), 0);
            if (v.bh) chk(n_rew == r0 + 1, "R6 rewind", n_rew - r0, 1);
            if (v.tc == 4'h8) begin
                chk(cts.size() == 1, "R10 ct count", cts.size(), 1);
                if (cts.size() == 1) chk(cts[0] == pk[3], "R10 ct value", cts[0], pk[3]);
            end else chk(cts.size() == 0, "R10 no ct", cts.size(), 0);
        end
        keep_cycstart = 0;

        // R12: write timing, one cycle after each beat
        clear_obs();
        build('{4'h4, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 4'h1}, 40);
        @(negedge clk);
        in_valid = 1; in_sop = 1; in_eop = 0; in_quad = pk[0];
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            if (k <= 3) begin
                chk(fifo_wr && fifo_wdata == pk[k-1] && !fifo_commit, "R12 header write",
                    fifo_wdata, pk[k-1]);
            end else begin
                chk(fifo_wr && fifo_commit && fifo_wdata == 32'h1, "R12 status write", fifo_wdata, 32'h1);
                chk(ack_valid && ack_code == 4'h1, "R8 ack with status", ack_code, 4'h1);
            end
            if (k < 4) begin
                in_sop = 0; in_eop = (k == 3); in_quad = pk[k];
                if (k == 3) chk(!fifo_wr || fifo_wdata != pk[3], "R4 crc not written", fifo_wdata, 0);
            end else begin
                in_valid = 0; in_eop = 0;
            end
        end
        repeat (2) @(negedge clk);

        // R11: overflow inside the header
        clear_obs(); r0 = n_rew;
        build('{4'h1, 2'd0, 3'd4, 1'b0, 1'b0, 1'b0, 4'h4}, 50);
        exn = 0;
        send(plen, 1, 3);
        repeat (2) @(negedge clk);
        cmp_ack("R11 busy ack", 4'h4);
        cmp_store("R11 nothing stored");
        chk(n_rew == r0 + 1, "R11 rewind", n_rew - r0, 1);

        // R11: overflow on the status write
        clear_obs(); r0 = n_rew;
        build('{4'h7, 2'd0, 3'd1, 1'b0, 1'b0, 1'b0, 4'h4}, 51);
        exn = 0;
        send(plen, 1, plen - 1);
        repeat (2) @(negedge clk);
        cmp_ack("R11 busy on status", 4'h4);
        cmp_store("R11 status overflow stored");
        chk(n_rew == r0 + 1, "R11 status rewind", n_rew - r0, 1);

        // R13: start marker mid-packet abandons the old one
        clear_obs(); r0 = n_rew;
        build('{4'h1, 2'd0, 3'd2, 1'b0, 1'b0, 1'b0, 4'h2}, 60);
        send(3, 0, -1);
        build('{4'h4, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 4'h1}, 61);
        send(plen, 1, -1);
        repeat (2) @(negedge clk);
        chk(n_rew == r0 + 1, "R13 abandon rewind", n_rew - r0, 1);
        cmp_store("R13 second packet stored");
        cmp_ack("R13 second ack", 4'h1);

        // R9: payload packet ending on its header CRC has no data CRC
        clear_obs();
        build('{4'h1, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 4'hD}, 70);
        send(hl + 1, 1, -1);
        repeat (2) @(negedge clk);
        cmp_ack("R9 missing data crc", 4'hD);
        cmp_store("R9 missing data crc store");

        // R6: end marker before the header CRC
        clear_obs(); r0 = n_rew;
        build('{4'h0, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 4'h0}, 80);
        send(2, 1, -1);
        repeat (2) @(negedge clk);
        cmp_ack("R6 truncated ack", 4'h0);
        chk(comm.size() == 0 && n_rew == r0 + 1, "R6 truncated rewind", n_rew - r0, 1);

        finish_run();
    end
endmodule